// File: doc/BRIEF.md
# DMA Chunking Data Mover

This block moves the payload of one transfer: one source descriptor paired with one destination descriptor. On a start pulse it captures the source and destination address, size and interrupt flag together with the transfer mode, the pointer mode and the burst type of each side. It then walks the byte count in chunks. For each chunk it emits a read request and then one or more write requests. A request is a single-cycle pulse carrying an address and a length. Write requests are split wherever the destination runs out or a fixed-burst cap applies.

In list (memory-pointer) mode a destination descriptor may be smaller than a chunk. When that happens the block stalls with `need_dst` raised until the surrounding fetch logic presents the next destination descriptor on the same destination inputs with `dst_load`. A 32-bit running byte total counts every chunk. Bits of the total are cleared by writing ones to `tot_clr`. The block pulses `done` when the byte count is used up, and pulses `dst_done` whenever a flagged destination empties.

Top module: `dcm_mover`

## Requirements
- R1: `xfer_mode` encodes 0 as read-and-write, 1 as write-only and 2 as read-only. When `ptr_mem` is 1 at start, the mode is treated as read-and-write and both burst types as incrementing, whatever their inputs say.
- R2: Each chunk length is the smallest of the remaining byte count, BUF_BYTES (64) and, when the read burst is fixed (`rd_burst`=0) or the mode is write-only, BUS_W/8 (8) bytes. Each chunk produces exactly one read request unless the mode is write-only.
- R3: For an incrementing burst (value 1), successive requests on that side advance the address by the previous length. For a fixed burst (value 0), the address stays at the start address and each write is at most BUS_W/8 bytes.
- R4: In write-only mode the byte count is the destination size and the source size is ignored. No read request is issued, and every write has `wr_fill`=1.
- R5: In read-only mode read requests are issued and no write request is issued.
- R6: In register mode (`ptr_mem`=0) with a mode other than write-only, the destination size is ignored and each chunk is written in full.
- R7: In list mode, when the destination size reaches 0 with chunk bytes still pending, `need_dst` rises and no request is issued. After `dst_load` the new descriptor's address, size and flag are taken and writing continues.
- R8: `dst_done` pulses when the remaining destination bytes reach 0 and the current destination interrupt flag is 1. Under R6 the remaining destination bytes are the bytes left in the current chunk.
- R9: `total_bytes` adds every chunk length. Ones written on `tot_clr` clear those bits in the same cycle.
- R10: `done` pulses once with `busy` low after the last request. A zero byte count gives `done` with no requests.
- R11: `start` is ignored while `busy` is high. The inputs are captured only at an accepted start.
- R12: After reset, `busy`, `need_dst`, `done`, `dst_done`, `rd_valid` and `wr_valid` are 0 and `total_bytes` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (ignored while busy) |
| ptr_mem | input | 1 | 1 = list (memory-pointer) mode, 0 = register mode |
| xfer_mode | input | 2 | 0 read-and-write, 1 write-only, 2 read-only |
| rd_burst | input | 1 | Read burst type: 0 fixed, 1 incrementing |
| wr_burst | input | 1 | Write burst type: 0 fixed, 1 incrementing |
| src_addr | input | AW | Source start address |
| src_size | input | SZW | Source byte count |
| dst_addr | input | AW | Destination address (at start or with dst_load) |
| dst_size | input | SZW | Destination byte count |
| dst_intr | input | 1 | Destination interrupt flag |
| dst_load | input | 1 | Next destination descriptor is valid |
| tot_clr | input | 32 | Write-one-to-clear mask for the total |
| rd_valid | output | 1 | Read request pulse |
| rd_addr | output | AW | Read address |
| rd_len | output | LW | Read length in bytes |
| wr_valid | output | 1 | Write request pulse |
| wr_addr | output | AW | Write address |
| wr_len | output | LW | Write length in bytes |
| wr_fill | output | 1 | Write data comes from the fixed fill pattern |
| need_dst | output | 1 | Waiting for the next destination descriptor |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished pulse |
| dst_done | output | 1 | Flagged destination emptied pulse |
| total_bytes | output | 32 | Running byte total |

## Verification
The hardest case to reach is a list-mode destination that empties partway through a chunk. This needs destination sizes that are not multiples of the chunk length, and it has to interact with fixed bursts that have been forced to incrementing. The stimulus builds chains of small, uneven destination descriptors and answers each `need_dst` with the next one from the chain. The source sizes cross several chunk boundaries and several descriptor boundaries. Directed cases add the register-mode override, where a tiny destination size has to be ignored, and a start that arrives with different inputs in the middle of a transfer.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_WAIT  = 2'd3
    } dcm_state_e;

    localparam logic [1:0] MODE_RW = 2'd0;
    localparam logic [1:0] MODE_WO = 2'd1;
    localparam logic [1:0] MODE_RO = 2'd2;
endpackage

// File: rtl/dcm_len_sel.sv
// Smallest of a remaining count, a second limit, the buffer depth and an optional cap.
module dcm_len_sel #(
    parameter int SZW       = 30,
    parameter int LW        = 7,
    parameter int BUF_BYTES = 64,
    parameter int CAP_BYTES = 8
) (
    input  logic [SZW-1:0] remain,
    input  logic [SZW-1:0] limit,
    input  logic           cap_en,
    output logic [LW-1:0]  len
);
    logic [SZW-1:0] m;

    always_comb begin
        m = remain;
        if (limit < m)
            m = limit;
        if (SZW'(BUF_BYTES) < m)
            m = SZW'(BUF_BYTES);
        if (cap_en && (SZW'(CAP_BYTES) < m))
            m = SZW'(CAP_BYTES);
        len = m[LW-1:0];
    end
endmodule

// File: rtl/dcm_addr_step.sv
// Next request address: advance by the length for incrementing bursts, hold for fixed.
module dcm_addr_step #(
    parameter int AW = 32,
    parameter int LW = 7
) (
    input  logic [AW-1:0] addr,
    input  logic [LW-1:0] len,
    input  logic          incr,
    output logic [AW-1:0] next
);
    always_comb begin
        next = incr ? (addr + AW'(len)) : addr;
    end
endmodule

// File: rtl/dcm_mover.sv
module dcm_mover
    import dcm_pkg::*;
#(
    parameter int AW        = 32,
    parameter int SZW       = 30,
    parameter int BUS_W     = 64,
    parameter int BUF_BYTES = 64,
    parameter int LW        = $clog2(BUF_BYTES + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           ptr_mem,
    input  logic [1:0]     xfer_mode,
    input  logic           rd_burst,
    input  logic           wr_burst,
    input  logic [AW-1:0]  src_addr,
    input  logic [SZW-1:0] src_size,
    input  logic [AW-1:0]  dst_addr,
    input  logic [SZW-1:0] dst_size,
    input  logic           dst_intr,
    input  logic           dst_load,
    input  logic [31:0]    tot_clr,
    output logic           rd_valid,
    output logic [AW-1:0]  rd_addr,
    output logic [LW-1:0]  rd_len,
    output logic           wr_valid,
    output logic [AW-1:0]  wr_addr,
    output logic [LW-1:0]  wr_len,
    output logic           wr_fill,
    output logic           need_dst,
    output logic           busy,
    output logic           done,
    output logic           dst_done,
    output logic [31:0]    total_bytes
);
    localparam int BEAT_BYTES = BUS_W / 8;

    typedef struct packed {
        dcm_state_e     st;
        logic [1:0]     mode;
        logic           mem;
        logic           rb_inc;
        logic           wb_inc;
        logic [AW-1:0]  sa;
        logic [AW-1:0]  da;
        logic [SZW-1:0] remain;
        logic [SZW-1:0] dleft;
        logic           dintr;
        logic [LW-1:0]  cleft;
        logic           rd_v;
        logic [AW-1:0]  rd_a;
        logic [LW-1:0]  rd_l;
        logic           wr_v;
        logic [AW-1:0]  wr_a;
        logic [LW-1:0]  wr_l;
        logic           wr_f;
        logic           dn;
        logic           dd;
        logic [31:0]    tot;
    } mover_t;

    mover_t q, d;

    logic [LW-1:0] rlen, wlen;
    logic [AW-1:0] sa_next, da_next;
    logic          ovr;
    logic [SZW-1:0] wlimit;

    // Register mode, not write-only: destination size is replaced by the chunk.
    assign ovr    = !q.mem && (q.mode != MODE_WO);
    assign wlimit = ovr ? SZW'(q.cleft) : q.dleft;

    dcm_len_sel #(.SZW(SZW), .LW(LW), .BUF_BYTES(BUF_BYTES), .CAP_BYTES(BEAT_BYTES)) u_rlen (
        .remain (q.remain),
        .limit  ({SZW{1'b1}}),
        .cap_en (!q.rb_inc || (q.mode == MODE_WO)),
        .len    (rlen)
    );

    dcm_len_sel #(.SZW(SZW), .LW(LW), .BUF_BYTES(BUF_BYTES), .CAP_BYTES(BEAT_BYTES)) u_wlen (
        .remain (SZW'(q.cleft)),
        .limit  (wlimit),
        .cap_en (!q.wb_inc),
        .len    (wlen)
    );

    dcm_addr_step #(.AW(AW), .LW(LW)) u_sa_step (
        .addr (q.sa), .len (rlen), .incr (q.rb_inc), .next (sa_next)
    );

    dcm_addr_step #(.AW(AW), .LW(LW)) u_da_step (
        .addr (q.da), .len (wlen), .incr (q.wb_inc), .next (da_next)
    );

    always_comb begin
        d      = q;
        d.rd_v = 1'b0;
        d.wr_v = 1'b0;
        d.dn   = 1'b0;
        d.dd   = 1'b0;
        d.tot  = q.tot & ~tot_clr;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.mem    = ptr_mem;
                    d.mode   = ptr_mem ? MODE_RW : xfer_mode;
                    d.rb_inc = ptr_mem | rd_burst;
                    d.wb_inc = ptr_mem | wr_burst;
                    d.sa     = src_addr;
                    d.da     = dst_addr;
                    d.dleft  = dst_size;
                    d.dintr  = dst_intr;
                    d.remain = (!ptr_mem && xfer_mode == MODE_WO) ? dst_size : src_size;
                    d.st     = ST_READ;
                end
            end
            ST_READ: begin
                if (q.remain == '0) begin
                    d.dn = 1'b1;
                    d.st = ST_IDLE;
                end else begin
                    if (q.mode != MODE_WO) begin
                        d.rd_v = 1'b1;
                        d.rd_a = q.sa;
                        d.rd_l = rlen;
                        d.sa   = sa_next;
                    end
                    d.tot    = (q.tot & ~tot_clr) + 32'(rlen);
                    d.remain = q.remain - SZW'(rlen);
                    d.cleft  = rlen;
                    if (q.mode != MODE_RO)
                        d.st = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (!ovr && q.dleft == '0) begin
                    d.st = ST_WAIT;
                end else begin
                    d.wr_v = 1'b1;
                    d.wr_a = q.da;
                    d.wr_l = wlen;
                    d.wr_f = (q.mode == MODE_WO);
                    d.da   = da_next;
                    if (!ovr)
                        d.dleft = q.dleft - SZW'(wlen);
                    d.cleft = q.cleft - wlen;
                    if (q.dintr && (wlimit == SZW'(wlen)))
                        d.dd = 1'b1;
                    if (q.cleft == wlen)
                        d.st = ST_READ;
                end
            end
            ST_WAIT: begin
                if (dst_load) begin
                    d.da    = dst_addr;
                    d.dleft = dst_size;
                    d.dintr = dst_intr;
                    d.st    = ST_WRITE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign rd_valid    = q.rd_v;
    assign rd_addr     = q.rd_a;
    assign rd_len      = q.rd_l;
    assign wr_valid    = q.wr_v;
    assign wr_addr     = q.wr_a;
    assign wr_len      = q.wr_l;
    assign wr_fill     = q.wr_f;
    assign need_dst    = (q.st == ST_WAIT);
    assign busy        = (q.st != ST_IDLE);
    assign done        = q.dn;
    assign dst_done    = q.dd;
    assign total_bytes = q.tot;
endmodule

// File: rtl/dcm_mover_chk.sv
module dcm_mover_chk #(
    parameter int LW        = 7,
    parameter int BUF_BYTES = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_valid,
    input logic [LW-1:0] rd_len,
    input logic          wr_valid,
    input logic [LW-1:0] wr_len,
    input logic          need_dst,
    input logic          busy,
    input logic          done,
    input logic [31:0]   tot_clr,
    input logic [31:0]   total_bytes
);
    // R2: every read carries a non-empty length no larger than the buffer
    p_rd_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_len != '0) && (32'(rd_len) <= BUF_BYTES));

    // R2: every write carries a non-empty length no larger than the buffer
    p_wr_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_len != '0) && (32'(wr_len) <= BUF_BYTES));

    // R2: at most one request per cycle
    p_one_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, wr_valid}));

    // R7: no request while waiting for a destination descriptor
    p_wait_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        need_dst |-> busy && !rd_valid && !wr_valid);

    // R10: completion leaves the mover idle
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !need_dst);

    // R9: without a clear the total never decreases
    p_total_grows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tot_clr) == 32'd0) |-> (total_bytes >= $past(total_bytes)));
endmodule

bind dcm_mover dcm_mover_chk #(.LW(LW), .BUF_BYTES(BUF_BYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_valid    (rd_valid),
    .rd_len      (rd_len),
    .wr_valid    (wr_valid),
    .wr_len      (wr_len),
    .need_dst    (need_dst),
    .busy        (busy),
    .done        (done),
    .tot_clr     (tot_clr),
    .total_bytes (total_bytes)
);

// File: tb/tb_dcm_mover.sv
module tb_dcm_mover;
    localparam int AW = 32;
    localparam int SZW = 30;
    localparam int LW = 7;
    localparam int NE = 1024;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 0, ptr_mem = 0, rd_burst = 1, wr_burst = 1, dst_intr = 0, dst_load = 0;
    logic [1:0] xfer_mode = 0;
    logic [AW-1:0] src_addr = 0, dst_addr = 0;
    logic [SZW-1:0] src_size = 0, dst_size = 0;
    logic [31:0] tot_clr = 0;
    logic rd_valid, wr_valid, wr_fill, need_dst, busy, done, dst_done;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [LW-1:0] rd_len, wr_len;
    logic [31:0] total_bytes;

    always #4 clk = ~clk;

    dcm_mover dut (.*);

    int n_chk = 0, n_fail = 0;

    // destination descriptor chain, entry 0 is presented at start
    logic [31:0] dl_addr [8];
    int          dl_size [8];
    bit          dl_intr [8];

    logic [31:0] e_ra [NE], e_wa [NE];
    int          e_rl [NE], e_wl [NE];
    bit          e_wf [NE];
    int ne_r, ne_w, e_dd;
    logic [31:0] e_tot;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic build_model(input bit mem, input logic [1:0] mode_i, input bit rb_i,
                               input bit wb_i, input logic [31:0] sa_i, input int ss);
        bit rb, wb, ovr, di;
        logic [1:0] mode;
        int rem, len, cl, dl, w, k;
        logic [31:0] sa, da;
        rb = rb_i | mem; wb = wb_i | mem; mode = mem ? 2'd0 : mode_i;
        rem = (mode == 2'd1) ? dl_size[0] : ss;
        sa = sa_i; da = dl_addr[0]; dl = dl_size[0]; di = dl_intr[0]; k = 1;
        ne_r = 0; ne_w = 0; e_dd = 0; e_tot = 0;
        ovr = !mem && mode != 2'd1;
        while (rem > 0) begin
            len = imin(rem, 64);
            if (!rb || mode == 2'd1) len = imin(len, 8);
            if (mode != 2'd1) begin
                e_ra[ne_r] = sa; e_rl[ne_r] = len; ne_r++;
                if (rb) sa = sa + 32'(len);
            end
            e_tot = e_tot + 32'(len);
            rem = rem - len;
            if (mode != 2'd2) begin
                cl = len;
                while (cl > 0) begin
                    if (!ovr && dl == 0) begin
                        da = dl_addr[k]; dl = dl_size[k]; di = dl_intr[k]; k++;
                    end else begin
                        w = ovr ? cl : imin(cl, dl);
                        if (!wb) w = imin(w, 8);
                        e_wa[ne_w] = da; e_wl[ne_w] = w; e_wf[ne_w] = (mode == 2'd1); ne_w++;
                        if (wb) da = da + 32'(w);
                        if (!ovr) dl = dl - w;
                        cl = cl - w;
                        if (((ovr ? cl : dl) == 0) && di) e_dd++;
                    end
                end
            end
        end
    endtask

    task automatic run_xfer(input bit mem, input logic [1:0] mode, input bit rb, input bit wb,
                            input logic [31:0] sa, input int ss, input bit inject, input string tag);
        int o_r, o_w, o_dd, k, cyc;
        bit seen_done;
        build_model(mem, mode, rb, wb, sa, ss);
        @(negedge clk); tot_clr = '1;
        @(negedge clk); tot_clr = '0;
        ptr_mem = mem; xfer_mode = mode; rd_burst = rb; wr_burst = wb;
        src_addr = sa; src_size = SZW'(ss);
        dst_addr = dl_addr[0]; dst_size = SZW'(dl_size[0]); dst_intr = dl_intr[0];
        start = 1;
        @(negedge clk); start = 0;
        o_r = 0; o_w = 0; o_dd = 0; k = 1; seen_done = 0; cyc = 0;
        while (!seen_done) begin
            @(negedge clk);
            cyc++;
            if (rd_valid) begin
                if (o_r < ne_r) begin
                    chk(rd_addr == e_ra[o_r], {tag, " R3 read addr"}, rd_addr, e_ra[o_r]);
                    chk(int'(rd_len) == e_rl[o_r], {tag, " R2 read len"}, rd_len, e_rl[o_r]);
                end else chk(0, {tag, " R5/R4 extra read"}, o_r + 1, ne_r);
                o_r++;
            end
            if (wr_valid) begin
                if (o_w < ne_w) begin
                    chk(wr_addr == e_wa[o_w], {tag, " R3 write addr"}, wr_addr, e_wa[o_w]);
                    chk(int'(wr_len) == e_wl[o_w], {tag, " R6 write len"}, wr_len, e_wl[o_w]);
                    chk(wr_fill == e_wf[o_w], {tag, " R4 fill flag"}, wr_fill, e_wf[o_w]);
                end else chk(0, {tag, " R5 extra write"}, o_w + 1, ne_w);
                o_w++;
            end
            if (dst_done) o_dd++;
            if (done) seen_done = 1;
            // R11: a second start with different inputs while busy
            if (inject && cyc == 3) begin
                start = 1; xfer_mode = 2'd2; src_addr = 32'hDEAD0000; src_size = 30'd7;
                rd_burst = ~rb; wr_burst = ~wb; ptr_mem = ~mem;
            end else start = 0;
            if (dst_load) dst_load = 0;
            else if (need_dst) begin
                dst_addr = dl_addr[k]; dst_size = SZW'(dl_size[k]); dst_intr = dl_intr[k];
                dst_load = 1; k++;
            end
            if (cyc > 5000) begin
                chk(0, {tag, " R10 watchdog"}, cyc, 0);
                seen_done = 1;
            end
        end
        dst_load = 0; start = 0;
        chk(busy == 0, {tag, " R10 idle after done"}, busy, 0);
        chk(o_r == ne_r, {tag, " R2 read count"}, o_r, ne_r);
        chk(o_w == ne_w, {tag, " R7 write count"}, o_w, ne_w);
        chk(o_dd == e_dd, {tag, " R8 dst_done count"}, o_dd, e_dd);
        chk(total_bytes == e_tot, {tag, " R9 total"}, total_bytes, e_tot);
    endtask

    task automatic set_chain(input logic [31:0] base, input int s0, input bit i0);
        for (int i = 0; i < 8; i++) begin
            dl_addr[i] = base + 32'(i * 32'h1000);
            dl_size[i] = (i == 7) ? 4096 : 1 + i;
            dl_intr[i] = 1'b1;
        end
        dl_size[0] = s0; dl_intr[0] = i0;
    endtask

    initial begin
        logic [31:0] snap;
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(busy == 0 && need_dst == 0 && done == 0 && dst_done == 0, "R12 idle flags", busy, 0);
        chk(rd_valid == 0 && wr_valid == 0, "R12 no requests", {rd_valid, wr_valid}, 0);
        chk(total_bytes == 0, "R12 total", total_bytes, 0);
        rst_n = 1;
        @(negedge clk);

        // R6: register mode, tiny destination size ignored, flag per chunk (R8)
        set_chain(32'h2000_0000, 3, 1);
        run_xfer(0, 2'd0, 1, 1, 32'h1000_0010, 150, 0, "reg-rw");
        // R3: fixed bursts on both sides
        set_chain(32'h3000_0000, 5, 1);
        run_xfer(0, 2'd0, 0, 0, 32'h1000_0100, 20, 0, "reg-fixed");
        // R4: write-only uses destination size
        set_chain(32'h4000_0000, 21, 1);
        run_xfer(0, 2'd1, 1, 1, 32'h1000_0200, 999, 0, "wo");
        // R5: read-only
        set_chain(32'h5000_0000, 9, 1);
        run_xfer(0, 2'd2, 1, 1, 32'h1000_0300, 100, 0, "ro");
        // R1 and R7: list mode forcing, destination chain 10,70,...
        set_chain(32'h6000_0000, 10, 1);
        dl_size[1] = 70; dl_intr[1] = 0;
        run_xfer(1, 2'd2, 0, 0, 32'h1000_0400, 180, 0, "list");
        // R10: zero size
        set_chain(32'h7000_0000, 4, 1);
        run_xfer(0, 2'd0, 1, 1, 32'h1000_0500, 0, 0, "zero");
        // R11: start while busy
        set_chain(32'h8000_0000, 5, 0);
        run_xfer(1, 2'd0, 1, 1, 32'h1000_0600, 130, 1, "restart");
        // R9: partial write-one-to-clear
        snap = total_bytes;
        @(negedge clk); tot_clr = 32'h0000_0012;
        @(negedge clk); tot_clr = 0;
        chk(total_bytes == (snap & ~32'h12), "R9 w1c", total_bytes, snap & ~32'h12);

        for (int t = 0; t < 24; t++) begin
            bit mem;
            logic [1:0] mode;
            mem = $urandom % 2;
            mode = 2'($urandom % 3);
            for (int i = 0; i < 8; i++) begin
                dl_addr[i] = $urandom;
                dl_size[i] = (i == 7) ? 4096 : 1 + ($urandom % 90);
                dl_intr[i] = $urandom % 2;
            end
            run_xfer(mem, mode, $urandom % 2, $urandom % 2, $urandom,
                     ($urandom % 8 == 0) ? 0 : int'($urandom % 200), 0, "rand");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule